// File: doc/BRIEF.md
# Cluster Power Sequencing Controller

This block steps a processor cluster through a full power-off and back on again. On a power-down request it first checks that every core has already reached its own shutdown state. It then runs an ordered handshake chain:

- mark the coherent accelerator port idle;
- raise a hardware L2 flush request and hold it until the flush completes;
- drive the coherence interface inactive;
- wait for the L2 memory system to report idle;
- close the output isolation clamps;
- ask the power switch to remove cluster and L2 power.

On a power-up request it holds the per-core and L2 resets low and keeps the L2 reset-disable control low. It then restores power and waits for power-good, followed by a fixed reset hold time. After that it opens the clamps and hands control to the cold reset sequence.

Each handshake wait has a timeout, programmable at run time. If the awaited input never arrives, the controller parks in a fault phase and sets a sticky error flag, which only a reset clears. A parameter selects which output carries the interface-inactive handshake: the snoop-inactive output or the system-inactive output. A three-bit phase output reports where the sequence stands. Requests that arrive in the wrong phase have no effect.

Top module: `cluster_pwr_seq`

## Requirements
- R1: After reset, phase is ON (0). The flush request, port idle, interface inactive, clamp, power-off, cold-go and error outputs are all low, and every core reset and the L2 reset are high (released).
- R2: In phase ON, a power-down request starts the sequence only while coresDown is high. Otherwise the phase stays ON and port idle stays low.
- R3: Port idle rises one cycle before the flush request rises. It stays high until the phase returns to ON.
- R4: The flush request stays high until flushDone is sampled high. The next cycle it is low, the phase is QUIESCING (2), and interface inactive is high.
- R5: With IF_CHI = 0, interface inactive appears on snoopInact and sysInact stays low. With IF_CHI = 1, the roles swap.
- R6: After l2Idle is sampled high, the phase is CLAMPED (3) for one cycle with the clamp high and power-off low. The phase then becomes OFF (4), with power-off and clamp both high.
- R7: A power-up request in OFF moves to POWERING_UP (5). In that phase power-off is low, the clamp is high, all core resets and the L2 reset are low, and L2 reset-disable is low.
- R8: The resets and clamp stay asserted for RST_HOLD (16) cycles after pwrGood is sampled. Then, for one cycle, the clamp is low while the resets are still low and coldGo is high. The next cycle the phase is ON with the resets released.
- R9: If a wait phase (flush, L2 idle, power-good) lasts tmoLimit cycles without its input, the phase becomes FAULT (6) and errFlag rises. Both hold until reset. tmoLimit = 0 disables the timeout.
- R10: A power-down request in OFF and a power-up request during flushing have no effect on the phase.
- R11: Phase encoding is ON = 0, FLUSHING = 1, QUIESCING = 2, CLAMPED = 3, OFF = 4, POWERING_UP = 5, FAULT = 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdReq | input | 1 | Power-down request |
| puReq | input | 1 | Power-up request |
| coresDown | input | 1 | All cores are in individual shutdown |
| flushDone | input | 1 | Hardware L2 flush finished |
| l2Idle | input | 1 | L2 memory system standby indication |
| pwrGood | input | 1 | Power switch reports domains powered |
| tmoLimit | input | TMO_W | Wait timeout in cycles, 0 disables |
| portIdle | output | 1 | Accelerator port inactive |
| flushReq | output | 1 | L2 hardware flush request |
| snoopInact | output | 1 | Snoop interface inactive (IF_CHI = 0) |
| sysInact | output | 1 | System interface inactive (IF_CHI = 1) |
| clampEn | output | 1 | Output isolation clamps enabled |
| pwrOffReq | output | 1 | Remove cluster and L2 power |
| coreRstN | output | NCORES | Per-core power-on resets, active low |
| l2RstN | output | 1 | L2 reset, active low |
| l2RstDis | output | 1 | L2 reset-disable control, held low |
| coldGo | output | 1 | Handoff to the cold reset sequence |
| errFlag | output | 1 | Sticky handshake timeout flag |
| phase | output | 3 | Current phase code |

## Verification
The bench randomizes the handshake delays around the timeout limit, including a delay of exactly limit minus one cycles, where a same-cycle arrival must win over the timeout. A design that counted one cycle off would fault on a good handshake or miss a late one. It also counts the reset hold window cycle by cycle and checks that the clamp opens before the resets release. A short hold, or releasing resets together with the clamp, shows up at that exact sample. Requests sent in the wrong phase, a power-down attempt without cores shut down, and a zero limit with a long delay catch designs that react to stray requests or time out when disabled.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [3:0] {
    S_ON, S_PORT, S_FLUSH, S_QUIESCE, S_CLAMP,
    S_OFF, S_PWRUP, S_HOLD, S_UNCLAMP, S_FAULT
  } seqState_t;

  // phase codes reported on the status output (R11)
  typedef enum logic [2:0] {
    PH_ON       = 3'd0,
    PH_FLUSHING = 3'd1,
    PH_QUIESCE  = 3'd2,
    PH_CLAMPED  = 3'd3,
    PH_OFF      = 3'd4,
    PH_PWRUP    = 3'd5,
    PH_FAULT    = 3'd6
  } phase_t;

  // strobes from control to counter datapath
  typedef struct packed {
    logic clrCnt;
    logic runTmo;
    logic runHold;
  } cntStrobe_t;

endpackage

// File: rtl/cps_timer.sv
module cps_timer
  import cps_pkg::*;
#(
  parameter int TMO_W    = 8,
  parameter int RST_HOLD = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [TMO_W-1:0] tmoLimit,
  output logic             tmoHit,
  output logic             holdDone
);
  localparam int HW = $clog2(RST_HOLD + 1);

  logic [TMO_W-1:0] tmoCnt;
  logic [HW-1:0]    holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoCnt <= '0;
    end else if (strobe.clrCnt) begin
      tmoCnt <= '0;
    end else if (strobe.runTmo) begin
      tmoCnt <= tmoCnt + TMO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.clrCnt) begin
      holdCnt <= '0;
    end else if (strobe.runHold) begin
      holdCnt <= holdCnt + HW'(1);
    end
  end

  // limit of zero turns the timeout off
  assign tmoHit   = strobe.runTmo && (tmoLimit != '0) &&
                    (tmoCnt == (tmoLimit - TMO_W'(1)));
  assign holdDone = strobe.runHold && (holdCnt == HW'(RST_HOLD - 1));

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCnt |=> (tmoCnt == '0) && (holdCnt == '0)); // R9

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobe.runHold |-> (holdCnt < HW'(RST_HOLD))); // R8

endmodule

// File: rtl/cps_ctrl.sv
module cps_ctrl
  import cps_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pdReq,
  input  logic              puReq,
  input  logic              coresDown,
  input  logic              flushDone,
  input  logic              l2Idle,
  input  logic              pwrGood,
  input  logic              tmoHit,
  input  logic              holdDone,
  output cntStrobe_t        strobe,
  output logic              portIdle,
  output logic              flushReq,
  output logic              ifInact,
  output logic              clampEn,
  output logic              pwrOffReq,
  output logic [NCORES-1:0] coreRstN,
  output logic              l2RstN,
  output logic              l2RstDis,
  output logic              coldGo,
  output logic              errFlag,
  output logic [2:0]        phase
);
  seqState_t st, nxt;
  logic rstHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_ON;
    else       st <= nxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              errFlag <= 1'b0;
    else if (nxt == S_FAULT) errFlag <= 1'b1;
  end

  always_comb begin
    nxt = st;
    unique case (st)
      S_ON:      if (pdReq && coresDown) nxt = S_PORT;
      S_PORT:    nxt = S_FLUSH;
      S_FLUSH: begin
        if (flushDone)   nxt = S_QUIESCE;
        else if (tmoHit) nxt = S_FAULT;
      end
      S_QUIESCE: begin
        if (l2Idle)      nxt = S_CLAMP;
        else if (tmoHit) nxt = S_FAULT;
      end
      S_CLAMP:   nxt = S_OFF;
      S_OFF:     if (puReq) nxt = S_PWRUP;
      S_PWRUP: begin
        if (pwrGood)     nxt = S_HOLD;
        else if (tmoHit) nxt = S_FAULT;
      end
      S_HOLD:    if (holdDone) nxt = S_UNCLAMP;
      S_UNCLAMP: nxt = S_ON;
      S_FAULT:   nxt = S_FAULT;
      default:   nxt = S_FAULT;
    endcase
  end

  always_comb begin
    strobe.clrCnt  = (nxt != st);
    strobe.runTmo  = (st == S_FLUSH) || (st == S_QUIESCE) || (st == S_PWRUP);
    strobe.runHold = (st == S_HOLD);
  end

  always_comb begin
    portIdle  = (st != S_ON);
    flushReq  = (st == S_FLUSH);
    ifInact   = !(st inside {S_ON, S_PORT, S_FLUSH});
    clampEn   = st inside {S_CLAMP, S_OFF, S_PWRUP, S_HOLD, S_FAULT};
    pwrOffReq = (st == S_OFF);
    rstHeld   = st inside {S_PWRUP, S_HOLD, S_UNCLAMP, S_FAULT};
    coldGo    = (st == S_UNCLAMP);
    // reset-disable stays low so the L2 is fully reset on every power-up
    l2RstDis  = 1'b0;
  end

  assign coreRstN = {NCORES{!rstHeld}};
  assign l2RstN   = !rstHeld;

  always_comb begin
    unique case (st)
      S_ON:                   phase = PH_ON;
      S_PORT, S_FLUSH:        phase = PH_FLUSHING;
      S_QUIESCE:              phase = PH_QUIESCE;
      S_CLAMP:                phase = PH_CLAMPED;
      S_OFF:                  phase = PH_OFF;
      S_PWRUP, S_HOLD,
      S_UNCLAMP:              phase = PH_PWRUP;
      default:                phase = PH_FAULT;
    endcase
  end

  AST_START_NEEDS_CORES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portIdle) |-> $past(coresDown)); // R2

  AST_PORT_BEFORE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flushReq) |-> $past(portIdle)); // R3

  AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && !flushDone && !tmoHit) |=> flushReq); // R4

  AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && flushDone) |=> (!flushReq && ifInact)); // R4

  AST_CLAMP_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrOffReq) |-> $past(clampEn)); // R6

  AST_UNCLAMP_BEFORE_RST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(l2RstN) |-> ($past(!clampEn) && !clampEn)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R9

endmodule

// File: rtl/cluster_pwr_seq.sv
module cluster_pwr_seq
  import cps_pkg::*;
#(
  parameter int NCORES   = 4,
  parameter int TMO_W    = 8,
  parameter int RST_HOLD = 16,
  parameter bit IF_CHI   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pdReq,
  input  logic              puReq,
  input  logic              coresDown,
  input  logic              flushDone,
  input  logic              l2Idle,
  input  logic              pwrGood,
  input  logic [TMO_W-1:0]  tmoLimit,
  output logic              portIdle,
  output logic              flushReq,
  output logic              snoopInact,
  output logic              sysInact,
  output logic              clampEn,
  output logic              pwrOffReq,
  output logic [NCORES-1:0] coreRstN,
  output logic              l2RstN,
  output logic              l2RstDis,
  output logic              coldGo,
  output logic              errFlag,
  output logic [2:0]        phase
);
  cntStrobe_t strobe;
  logic tmoHit, holdDone, ifInact;

  cps_ctrl #(.NCORES(NCORES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .puReq(puReq),
    .coresDown(coresDown), .flushDone(flushDone), .l2Idle(l2Idle),
    .pwrGood(pwrGood), .tmoHit(tmoHit), .holdDone(holdDone),
    .strobe(strobe), .portIdle(portIdle), .flushReq(flushReq),
    .ifInact(ifInact), .clampEn(clampEn), .pwrOffReq(pwrOffReq),
    .coreRstN(coreRstN), .l2RstN(l2RstN), .l2RstDis(l2RstDis),
    .coldGo(coldGo), .errFlag(errFlag), .phase(phase)
  );

  cps_timer #(.TMO_W(TMO_W), .RST_HOLD(RST_HOLD)) u_timer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tmoLimit(tmoLimit),
    .tmoHit(tmoHit), .holdDone(holdDone)
  );

  // route the quiesce handshake to the interface style in use (R5)
  generate
    if (IF_CHI) begin : g_sys
      assign sysInact   = ifInact;
      assign snoopInact = 1'b0;
    end else begin : g_snoop
      assign snoopInact = ifInact;
      assign sysInact   = 1'b0;
    end
  endgenerate

endmodule

// File: tb/cluster_pwr_seq_bench.sv
module cluster_pwr_seq_bench;
  localparam int NC = 4;
  localparam int TW = 8;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdReq = 0, puReq = 0, coresDown = 0, flushDone = 0, l2Idle = 0, pwrGood = 0;
  logic [TW-1:0] tmoLimit = '0;
  logic portIdle, flushReq, snoopInact, sysInact, clampEn, pwrOffReq;
  logic [NC-1:0] coreRstN;
  logic l2RstN, l2RstDis, coldGo, errFlag;
  logic [2:0] phase;
  logic cPortIdle, cFlushReq, cSnoop, cSys, cClamp, cPwrOff;
  logic [NC-1:0] cCoreRstN;
  logic cL2RstN, cL2RstDis, cColdGo, cErr;
  logic [2:0] cPhase;

  int nChk = 0;
  int nErr = 0;

  always #5 clk = ~clk;

  cluster_pwr_seq #(.NCORES(NC), .TMO_W(TW), .RST_HOLD(HOLD), .IF_CHI(1'b0)) u_cluster_pwr_seq (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .puReq(puReq), .coresDown(coresDown),
    .flushDone(flushDone), .l2Idle(l2Idle), .pwrGood(pwrGood), .tmoLimit(tmoLimit),
    .portIdle(portIdle), .flushReq(flushReq), .snoopInact(snoopInact), .sysInact(sysInact),
    .clampEn(clampEn), .pwrOffReq(pwrOffReq), .coreRstN(coreRstN), .l2RstN(l2RstN),
    .l2RstDis(l2RstDis), .coldGo(coldGo), .errFlag(errFlag), .phase(phase));

  cluster_pwr_seq #(.NCORES(NC), .TMO_W(TW), .RST_HOLD(HOLD), .IF_CHI(1'b1)) u_cluster_pwr_seq_chi (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .puReq(puReq), .coresDown(coresDown),
    .flushDone(flushDone), .l2Idle(l2Idle), .pwrGood(pwrGood), .tmoLimit(tmoLimit),
    .portIdle(cPortIdle), .flushReq(cFlushReq), .snoopInact(cSnoop), .sysInact(cSys),
    .clampEn(cClamp), .pwrOffReq(cPwrOff), .coreRstN(cCoreRstN), .l2RstN(cL2RstN),
    .l2RstDis(cL2RstDis), .coldGo(cColdGo), .errFlag(cErr), .phase(cPhase));

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // handshake arriving after d idle cycles succeeds unless the limit expires first
  function automatic bit expOk(input int d, input int lim);
    return (lim == 0) || (d < lim);
  endfunction

  task automatic applyReset();
    rstN = 1'b0;
    pdReq = 0; puReq = 0; coresDown = 0; flushDone = 0; l2Idle = 0; pwrGood = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic checkFault(input string req);
    chk({req, " phase FAULT"}, phase, 6);
    chk({req, " errFlag"}, errFlag, 1);
    chk({req, " flushReq low"}, flushReq, 0);
  endtask

  task automatic runTrial(input int lim, input int dF, input int dI, input int dP);
    int bad;
    applyReset();
    tmoLimit = TW'(lim);
    coresDown = 1; pdReq = 1;
    @(negedge clk);
    pdReq = 0; puReq = 1;                 // R10: ignored while sequence runs
    chk("R3 port idle before flush", {portIdle, flushReq}, 2);
    chk("R11 phase FLUSHING", phase, 1);
    @(negedge clk);
    puReq = 0;
    chk("R4 flush request high", flushReq, 1);
    chk("R10 puReq ignored in flush", phase, 1);
    for (int k = 0; k < dF; k++) @(negedge clk);
    flushDone = 1;
    @(negedge clk);
    flushDone = 0;
    if (!expOk(dF, lim)) begin checkFault("R9 flush timeout"); return; end
    chk("R4 flush dropped, QUIESCING", {flushReq, phase}, 2);
    chk("R5 snoop-style inactive", {snoopInact, sysInact}, 2);
    chk("R5 system-style inactive", {cSnoop, cSys}, 1);
    for (int k = 0; k < dI; k++) @(negedge clk);
    l2Idle = 1;
    @(negedge clk);
    l2Idle = 0;
    if (!expOk(dI, lim)) begin checkFault("R9 idle timeout"); return; end
    chk("R6 CLAMPED clamp=1 off=0", {phase, clampEn, pwrOffReq}, {3'd3, 2'b10});
    @(negedge clk);
    chk("R6 OFF clamp=1 off=1", {phase, clampEn, pwrOffReq}, {3'd4, 2'b11});
    pdReq = 1;
    @(negedge clk);
    pdReq = 0;
    chk("R10 pdReq ignored in OFF", phase, 4);
    puReq = 1;
    @(negedge clk);
    puReq = 0;
    chk("R7 POWERING_UP resets held", {phase, pwrOffReq, clampEn, coreRstN, l2RstN, l2RstDis},
        {3'd5, 1'b0, 1'b1, {NC{1'b0}}, 1'b0, 1'b0});
    for (int k = 0; k < dP; k++) @(negedge clk);
    pwrGood = 1;
    @(negedge clk);
    if (!expOk(dP, lim)) begin pwrGood = 0; checkFault("R9 power-good timeout"); return; end
    bad = 0;
    for (int k = 0; k < HOLD; k++) begin
      if (clampEn !== 1'b1 || l2RstN !== 1'b0 || coreRstN !== '0) bad++;
      @(negedge clk);
    end
    chk("R8 hold window cycles wrong", bad, 0);
    chk("R8 unclamp before reset release", {clampEn, l2RstN, coldGo, phase}, {3'b001, 3'd5});
    @(negedge clk);
    pwrGood = 0;
    chk("R8 back ON resets released", {phase, l2RstN, coreRstN, coldGo}, {3'd0, 1'b1, {NC{1'b1}}, 1'b0});
    chk("R3 port idle cleared in ON", portIdle, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog R1..all actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    applyReset();
    chk("R1 phase ON", phase, 0);
    chk("R1 outputs idle", {portIdle, flushReq, snoopInact, clampEn, pwrOffReq, coldGo, errFlag}, 0);
    chk("R1 resets released", {coreRstN, l2RstN}, {(NC+1){1'b1}});

    // R2: request without cores shut down is ignored
    tmoLimit = TW'(8);
    pdReq = 1; coresDown = 0;
    repeat (3) @(negedge clk);
    chk("R2 no start without coresDown", {phase, portIdle}, 0);
    pdReq = 0;

    // directed: full sequence, boundary delay limit-1 wins over timeout
    runTrial(6, 5, 5, 5);
    // directed: delay equal to limit faults in each wait
    runTrial(4, 4, 0, 0);
    runTrial(4, 0, 4, 0);
    runTrial(4, 0, 0, 4);
    // R9: zero limit disables timeout even for long waits
    runTrial(0, 30, 30, 30);
    chk("R9 disabled timeout no error", errFlag, 0);

    // R9: error stays sticky while requests come in
    runTrial(2, 9, 0, 0);
    puReq = 1; pdReq = 1;
    repeat (5) @(negedge clk);
    puReq = 0; pdReq = 0;
    chk("R9 fault parked", phase, 6);
    chk("R9 errFlag sticky", errFlag, 1);

    for (int t = 0; t < 24; t++) begin
      int lim;
      lim = (($urandom % 8) == 0) ? 0 : int'($urandom % 10) + 1;
      runTrial(lim, int'($urandom % 12), int'($urandom % 12), int'($urandom % 12));
    end

    summary();
    $finish;
  end
endmodule